// File: doc/BRIEF.md
# Flagged Sample Holding Register

This block keeps the latest result of one measurement channel in a 16-bit word for a host to read. An internal sample-update strobe loads the word. The host reads it over a serial link, and a one-cycle read strobe tells the block that a read took place. The word carries two status bits above the data. One bit shows that the host has not yet read the current sample. The other bit shows that an alarm was active when the sample was taken.

The data field is justified to bit 0. A parameter sets the channel width to 14 or 12 bits. In a 12-bit channel the two spare field bits always read as zero. Signed channels deliver two's complement values, and unsigned channels deliver plain binary. In both cases the sample bits pass through unchanged. The flags and the data are loaded on the same clock edge, so a read never returns a word that mixes two samples.

Top module: `flagged_sample_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the output word is 0x0000.
- R2: An update loads the sample into bits 13:0 of the word, justified to bit 0. Bit 15 is the new-data flag and bit 14 is the alarm flag. The new value appears in the cycle after the strobe.
- R3: When CHAN_BITS is 12, bits 13:12 of the word always read 0 and bits 11:0 hold sample bits 11:0.
- R4: An update sets the new-data flag (bit 15) to 1.
- R5: A read strobe without an update clears bit 15 in the next cycle. Bits 14:0 are left unchanged.
- R6: When an update and a read strobe arrive in the same cycle, the update wins. Bit 15 ends at 1 and the word holds the new sample.
- R7: Bit 14 takes the value of the alarm input on the update's clock edge. An alarm change without an update leaves bit 14 unchanged.
- R8: Without an update, changes on the sample input leave bits 13:0 unchanged.
- R9: In a 14-bit channel, two's complement values pass through bit-exact, including the most negative code 0x2000 and -1 (0x3FFF).
- R10: After a read, bit 15 stays 0 through further reads and idle cycles until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Reset, active low, synchronous |
| smp_i | input | 14 | Sample value from the conversion path |
| smp_vld_i | input | 1 | One-cycle sample-update strobe |
| alarm_i | input | 1 | Active alarm condition |
| rd_i | input | 1 | One-cycle strobe marking a host read |
| word_o | output | 16 | Packed word: new-data flag, alarm flag, data |

## Verification
Assertions check the flag rules on every clock. An update must leave the new-data flag set, with the masked sample and the alarm value in place. A lone read must clear the new-data flag and leave the rest of the word untouched. A cycle with no update must keep the data field and the alarm flag stable. Only the bench's scenarios can show that particular values come through correctly: the two's complement extremes, the zero spare bits of the 12-bit variant, and the result of a collision followed by later reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int WORD_W  = 16;
    localparam int FIELD_W = 14;

    typedef struct packed {
        logic               err;
        logic [FIELD_W-1:0] data;
    } fsr_body_t;
endpackage

// File: rtl/fsr_field_fmt.sv
module fsr_field_fmt
    import fsr_pkg::*;
#(
    parameter int CHAN_BITS = 14
) (
    input  logic [FIELD_W-1:0] raw_i,
    output logic [FIELD_W-1:0] field_o
);
    localparam int USE_W = (CHAN_BITS >= FIELD_W) ? FIELD_W : CHAN_BITS;

    generate
        if (USE_W == FIELD_W) begin : g_full
            assign field_o = raw_i;
        end else begin : g_narrow
            assign field_o = {{(FIELD_W-USE_W){1'b0}}, raw_i[USE_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/fsr_nd_ctl.sv
module fsr_nd_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic upd_i,
    input  logic rd_i,
    output logic nd_o
);
    logic nd_d, nd_q;

    always_comb begin
        nd_d = nd_q;
        if (upd_i)     nd_d = 1'b1;
        else if (rd_i) nd_d = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) nd_q <= 1'b0;
        else         nd_q <= nd_d;
    end

    assign nd_o = nd_q;

    // R4 R6
    nd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_i |=> nd_o);
    // R5
    nd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !upd_i) |=> !nd_o);
    // R10
    nd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_i && !upd_i) |=> $stable(nd_o));
endmodule

// File: rtl/flagged_sample_reg.sv
module flagged_sample_reg
    import fsr_pkg::*;
#(
    parameter int CHAN_BITS = 14
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [FIELD_W-1:0]   smp_i,
    input  logic                 smp_vld_i,
    input  logic                 alarm_i,
    input  logic                 rd_i,
    output logic [WORD_W-1:0]    word_o
);
    localparam int USE_W = (CHAN_BITS >= FIELD_W) ? FIELD_W : CHAN_BITS;
    localparam logic [FIELD_W-1:0] KEEP_MASK = FIELD_W'((1 << USE_W) - 1);

    logic [FIELD_W-1:0] field_w;
    logic               nd_w;
    fsr_body_t          body_d, body_q;

    fsr_field_fmt #(.CHAN_BITS(CHAN_BITS)) fmt_i (
        .raw_i   (smp_i),
        .field_o (field_w)
    );

    fsr_nd_ctl nd_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (smp_vld_i),
        .rd_i   (rd_i),
        .nd_o   (nd_w)
    );

    always_comb begin
        body_d = body_q;
        if (smp_vld_i) begin
            body_d.data = field_w;
            body_d.err  = alarm_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) body_q <= '0;
        else         body_q <= body_d;
    end

    assign word_o = {nd_w, body_q.err, body_q.data};

    // R2 R3
    load_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_i |=> word_o[FIELD_W-1:0] == ($past(smp_i) & KEEP_MASK));
    // R7
    load_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_i |=> word_o[14] == $past(alarm_i));
    // R8 R7
    hold_body_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_vld_i |=> $stable(word_o[14:0]));
    // R3
    spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_o[FIELD_W-1:0] & ~KEEP_MASK) == '0);
endmodule

// File: tb/flagged_sample_reg_tb.sv
module flagged_sample_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp = '0;
    logic        vld = 1'b0, alarm = 1'b0, rd = 1'b0;
    logic [15:0] word, word12;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flagged_sample_reg #(.CHAN_BITS(14)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(vld),
        .alarm_i(alarm), .rd_i(rd), .word_o(word));

    flagged_sample_reg #(.CHAN_BITS(12)) dut12_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(vld),
        .alarm_i(alarm), .rd_i(rd), .word_o(word12));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, result sampled at the next negedge
    task automatic cyc(input logic v, input logic r, input logic a, input logic [13:0] s);
        vld = v; rd = r; alarm = a; smp = s;
        @(negedge clk);
        vld = 1'b0; rd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", word, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", word, 16'h0000);
        check("R1 12-bit after release", word12, 16'h0000);
    endtask

    task automatic t_update();
        cyc(1, 0, 0, 14'h1234);
        check("R2 R4 update", word, 16'h9234);
        cyc(1, 0, 0, 14'h0001);
        check("R2 second update", word, 16'h8001);
    endtask

    task automatic t_read();
        cyc(0, 1, 0, 14'h3333);
        check("R5 read clears nd", word, 16'h0001);
        cyc(0, 1, 0, 14'h3333);
        check("R10 repeated read", word, 16'h0001);
        cyc(0, 0, 0, 14'h2222);
        check("R10 idle after read", word, 16'h0001);
    endtask

    task automatic t_collision();
        cyc(1, 1, 0, 14'h0ABC);
        check("R6 update beats read", word, 16'h8ABC);
        cyc(0, 1, 0, 14'h0ABC);
        check("R6 later read clears", word, 16'h0ABC);
    endtask

    task automatic t_alarm();
        cyc(1, 0, 1, 14'h0055);
        check("R7 alarm captured", word, 16'hC055);
        cyc(0, 0, 0, 14'h0055);
        check("R7 alarm drop ignored", word, 16'hC055);
        cyc(0, 1, 0, 14'h0055);
        check("R5 read keeps err", word, 16'h4055);
        cyc(1, 0, 0, 14'h0066);
        check("R7 alarm cleared on update", word, 16'h8066);
        cyc(0, 0, 1, 14'h0066);
        check("R7 alarm rise ignored", word, 16'h8066);
    endtask

    task automatic t_hold();
        cyc(0, 0, 0, 14'h3FFF);
        cyc(0, 0, 0, 14'h1111);
        check("R8 sample change ignored", word, 16'h8066);
    endtask

    task automatic t_signed();
        cyc(1, 0, 0, 14'h2000);
        check("R9 most negative", word, 16'hA000);
        cyc(1, 0, 0, 14'h3FFF);
        check("R9 minus one", word, 16'hBFFF);
        cyc(1, 0, 0, 14'h1FFF);
        check("R9 most positive", word, 16'h9FFF);
    endtask

    task automatic t_twelve();
        cyc(1, 0, 0, 14'h3FFF);
        check("R3 12-bit spare bits zero", word12, 16'h8FFF);
        cyc(1, 0, 1, 14'h2ABC);
        check("R3 12-bit masked data", word12, 16'hCABC);
        cyc(0, 1, 0, 14'h3FFF);
        check("R3 R5 12-bit read", word12, 16'h4ABC);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_update();
        t_read();
        t_collision();
        t_alarm();
        t_hold();
        t_signed();
        t_twelve();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule